// File: doc/BRIEF.md
# GPIO Pad Event and Interrupt Controller

This block serves a bank of general-purpose pads. Each pad has a configuration word that selects its function, controls its output driver and input receiver, holds the value driven out, shows the sampled input value, and chooses how incoming activity becomes an event. A pad can detect a level, a single edge or both edges, and can invert its input first. Pads are gathered into groups of up to `GROUP_SIZE`. Each group keeps a sticky interrupt status word, an interrupt enable word, a sticky wake status word, a wake enable word and a host-ownership word.

Software reaches all of this through a plain 32-bit register bus. Each write takes one cycle. A read returns its data one cycle after the read strobe. The block reduces all groups to one registered interrupt line and one registered wake line. A pad that the host does not own still works as plain GPIO, but its events never reach the status words.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset every interrupt, wake and enable bit reads 0, and every valid pad has its host-ownership bit set. Every pad's config word reads 0x0400_0100 (event code 2, output driver disabled). pad_oe, irq_out and wake_out are all 0.
- R2: The config word has these fields: bit 0 is the output value and appears on pad_out. Bit 1 is read-only and shows the synchronized input, or 0 when the receiver is disabled. Bit 8 disables the driver and bit 9 disables the receiver. Bits 13:10 are the pad mode. pad_oe is high only when the mode is 0 and bit 8 is clear.
- R3: Event code 0 (bits 26:25) is level mode. The status bit sets on every cycle the input is high, or low when invert bit 23 is set. It sets again right after a clear while that level persists.
- R4: Event code 1 sets the status bit once per rising edge. With invert set, it sets once per falling edge instead.
- R5: Event code 3 sets the status bit on both rising and falling edges.
- R6: Event code 2 produces no events. A disabled receiver (bit 9) produces no events even in inverted level mode.
- R7: Interrupt status is write-1-to-clear. Each 1 clears only its own bit, which is the pad index modulo the group size, and 0xFFFF clears a whole group. An event in the same cycle as a clear wins.
- R8: irq_out is the registered OR, over all groups, of status AND enable. Bits above the last valid pad of the last group always read 0 in every group word.
- R9: When a pad's ownership bit (word at 0x0C0 + 4*group) is clear, its interrupt and wake status bits never set. Its config word and input readback keep working.
- R10: Events of owned pads set wake status (0x140 + 4*group, write-1-to-clear). wake_out rises when a wake status bit and its wake enable bit (0x160 + 4*group) are both set and the pad's SCI route bit 19 is clear.
- R11: Config word 0 of pad p is at 0x400 + 8*p, and the second word at 0x404 + 8*p reads 0. Interrupt status is at 0x100 + 4*group and interrupt enable is at 0x120 + 4*group. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| pad_in | input | NUM_PADS | Asynchronous pad input values |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oe | output | NUM_PADS | Pad output enables |
| irq_out | output | 1 | Combined registered interrupt |
| wake_out | output | 1 | Combined registered wake |

## Verification
Each pad input is driven with held highs, held lows, single rising transitions and single falling transitions under every event code, with and without inversion. This separates level mode from edge mode, one edge polarity from the other, and single-edge mode from both-edge mode. Clears are issued while a level is still present and while it is gone, which distinguishes sticky re-setting from a real clear. Two pads are raised together and cleared one at a time to expose wrong bit placement. The last, partly filled group is written with all ones, an unowned pad is toggled, and the SCI route bit is flipped while wake is pending; each of these checks one gating path.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int unsigned B_TX     = 0;
    localparam int unsigned B_RX     = 1;
    localparam int unsigned B_TXDIS  = 8;
    localparam int unsigned B_RXDIS  = 9;
    localparam int unsigned B_MODE   = 10;
    localparam int unsigned B_NMI    = 17;
    localparam int unsigned B_SMI    = 18;
    localparam int unsigned B_SCI    = 19;
    localparam int unsigned B_IOAPIC = 20;
    localparam int unsigned B_INV    = 23;
    localparam int unsigned B_EVT    = 25;

    typedef enum logic [1:0] {
        EVT_LEVEL = 2'd0,
        EVT_EDGE  = 2'd1,
        EVT_OFF   = 2'd2,
        EVT_BOTH  = 2'd3
    } evt_mode_e;

    typedef struct packed {
        evt_mode_e  evt_mode;
        logic       rx_inv;
        logic       route_ioapic;
        logic       route_sci;
        logic       route_smi;
        logic       route_nmi;
        logic [3:0] pad_mode;
        logic       rx_dis;
        logic       tx_dis;
        logic       tx_val;
    } pad_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OWN,
        SEL_ISTS,
        SEL_IEN,
        SEL_WSTS,
        SEL_WEN,
        SEL_CFG0,
        SEL_CFG1
    } reg_sel_e;

    localparam pad_cfg_t CFG_RESET = '{
        evt_mode:     EVT_OFF,
        rx_inv:       1'b0,
        route_ioapic: 1'b0,
        route_sci:    1'b0,
        route_smi:    1'b0,
        route_nmi:    1'b0,
        pad_mode:     4'd0,
        rx_dis:       1'b0,
        tx_dis:       1'b1,
        tx_val:       1'b0
    };

    function automatic pad_cfg_t cfg_unpack(input logic [31:0] w);
        pad_cfg_t c;
        c.tx_val       = w[B_TX];
        c.tx_dis       = w[B_TXDIS];
        c.rx_dis       = w[B_RXDIS];
        c.pad_mode     = w[B_MODE +: 4];
        c.route_nmi    = w[B_NMI];
        c.route_smi    = w[B_SMI];
        c.route_sci    = w[B_SCI];
        c.route_ioapic = w[B_IOAPIC];
        c.rx_inv       = w[B_INV];
        c.evt_mode     = evt_mode_e'(w[B_EVT +: 2]);
        return c;
    endfunction

    function automatic logic [31:0] cfg_pack(input pad_cfg_t c, input logic rx);
        logic [31:0] w;
        w              = '0;
        w[B_TX]        = c.tx_val;
        w[B_RX]        = rx;
        w[B_TXDIS]     = c.tx_dis;
        w[B_RXDIS]     = c.rx_dis;
        w[B_MODE +: 4] = c.pad_mode;
        w[B_NMI]       = c.route_nmi;
        w[B_SMI]       = c.route_smi;
        w[B_SCI]       = c.route_sci;
        w[B_IOAPIC]    = c.route_ioapic;
        w[B_INV]       = c.rx_inv;
        w[B_EVT +: 2]  = c.evt_mode;
        return w;
    endfunction

    function automatic logic pad_drives(input pad_cfg_t c);
        return (c.pad_mode == 4'd0) && !c.tx_dis;
    endfunction

    function automatic logic detect(input evt_mode_e m, input logic cur, input logic prev);
        logic hit;
        case (m)
            EVT_LEVEL: hit = cur;
            EVT_EDGE:  hit = cur & ~prev;
            EVT_BOTH:  hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_evt_pad.sv
module gpio_evt_pad
    import gpio_evt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        pad_in,
    output pad_cfg_t    cfg_q,
    output logic        rx_val,
    output logic        evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_we) begin
            cfg_q <= cfg_unpack(cfg_wdata);
        end
    end

    assign rx_val = sync_q[SYNC_STAGES-1] & ~cfg_q.rx_dis;
    assign cur    = ~cfg_q.rx_dis & (sync_q[SYNC_STAGES-1] ^ cfg_q.rx_inv);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= cur;
        end
    end

    assign evt = ~cfg_q.rx_dis & detect(cfg_q.evt_mode, cur, prev_q);

    // R4: a single-edge pad cannot report two events in back-to-back cycles
    a_r4_edge_once: assert property (@(posedge clk) disable iff (rst)
        (evt && cfg_q.evt_mode == EVT_EDGE && !cfg_we) |=> !evt);

endmodule

// File: rtl/gpio_evt_group.sv
module gpio_evt_group #(
    parameter int unsigned GROUP_SIZE = 16,
    parameter int unsigned VALID_PADS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [GROUP_SIZE-1:0] evt,
    input  logic [GROUP_SIZE-1:0] sci,
    input  logic                  wr_own,
    input  logic                  wr_ists,
    input  logic                  wr_ien,
    input  logic                  wr_wsts,
    input  logic                  wr_wen,
    input  logic [GROUP_SIZE-1:0] wdata,
    output logic [GROUP_SIZE-1:0] own_q,
    output logic [GROUP_SIZE-1:0] ists_q,
    output logic [GROUP_SIZE-1:0] ien_q,
    output logic [GROUP_SIZE-1:0] wsts_q,
    output logic [GROUP_SIZE-1:0] wen_q,
    output logic                  irq_hit,
    output logic                  wake_hit
);

    localparam logic [GROUP_SIZE-1:0] VALID =
        GROUP_SIZE'((33'(1) << VALID_PADS) - 33'(1));

    logic [GROUP_SIZE-1:0] hit;
    logic [GROUP_SIZE-1:0] ists_clr;
    logic [GROUP_SIZE-1:0] wsts_clr;

    assign hit      = evt & own_q & VALID;
    assign ists_clr = wr_ists ? wdata : '0;
    assign wsts_clr = wr_wsts ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= VALID;
            ists_q <= '0;
            ien_q  <= '0;
            wsts_q <= '0;
            wen_q  <= '0;
        end else begin
            ists_q <= (ists_q & ~ists_clr) | hit;
            wsts_q <= (wsts_q & ~wsts_clr) | hit;
            if (wr_own) own_q <= wdata & VALID;
            if (wr_ien) ien_q <= wdata & VALID;
            if (wr_wen) wen_q <= wdata & VALID;
        end
    end

    assign irq_hit  = |(ists_q & ien_q);
    assign wake_hit = |(wsts_q & wen_q & ~sci);

    // R7: an all-ones clear with no event in flight empties the status word
    a_r7_clear_group: assert property (@(posedge clk) disable iff (rst)
        (wr_ists && wdata == '1 && evt == '0) |=> ists_q == '0);

    // R9: with no owned pad and no clear, interrupt status cannot move
    a_r9_unowned_frozen: assert property (@(posedge clk) disable iff (rst)
        (own_q == '0 && !wr_ists) |=> $stable(ists_q));

    // R10: wake status of an unowned group likewise cannot move
    a_r10_wake_owned: assert property (@(posedge clk) disable iff (rst)
        (own_q == '0 && !wr_wsts) |=> $stable(wsts_q));

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NUM_PADS    = 20,
    parameter int unsigned GROUP_SIZE  = 16,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic                irq_out,
    output logic                wake_out
);

    localparam int unsigned NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE;
    localparam int unsigned PAD_SPAN   = NUM_GROUPS * GROUP_SIZE;
    localparam int unsigned PIDX_W     = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
    localparam int unsigned GIDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int unsigned WIN_W      = ADDR_W - 5;
    localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(12'h400);
    localparam logic [ADDR_W-1:0] CFG_END  = ADDR_W'(12'h400 + 8 * NUM_PADS);

    // decode
    reg_sel_e          sel;
    logic [PIDX_W-1:0] pad_sel;
    logic [GIDX_W-1:0] grp_sel;

    always_comb begin
        sel     = SEL_NONE;
        pad_sel = PIDX_W'((bus_addr - CFG_BASE) >> 3);
        grp_sel = GIDX_W'(bus_addr[4:2]);
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr >= CFG_BASE && bus_addr < CFG_END) begin
                sel = bus_addr[2] ? SEL_CFG1 : SEL_CFG0;
            end else if ({1'b0, bus_addr[4:2]} < 4'(NUM_GROUPS)) begin
                case (bus_addr[ADDR_W-1:5])
                    WIN_W'(6):  sel = SEL_OWN;
                    WIN_W'(8):  sel = SEL_ISTS;
                    WIN_W'(9):  sel = SEL_IEN;
                    WIN_W'(10): sel = SEL_WSTS;
                    WIN_W'(11): sel = SEL_WEN;
                    default:    sel = SEL_NONE;
                endcase
            end
        end
    end

    // pads
    pad_cfg_t              cfg_arr [NUM_PADS];
    logic [NUM_PADS-1:0]   rx_arr;
    logic [NUM_PADS-1:0]   evt_arr;
    logic [PAD_SPAN-1:0]   evt_all;
    logic [PAD_SPAN-1:0]   sci_all;

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        gpio_evt_pad #(.SYNC_STAGES(SYNC_STAGES)) u_pad (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (bus_we && sel == SEL_CFG0 && pad_sel == PIDX_W'(p)),
            .cfg_wdata (bus_wdata),
            .pad_in    (pad_in[p]),
            .cfg_q     (cfg_arr[p]),
            .rx_val    (rx_arr[p]),
            .evt       (evt_arr[p])
        );
        assign pad_out[p] = cfg_arr[p].tx_val;
        assign pad_oe[p]  = pad_drives(cfg_arr[p]);
    end

    for (genvar s = 0; s < PAD_SPAN; s++) begin : g_span
        if (s < NUM_PADS) begin : g_real
            assign evt_all[s] = evt_arr[s];
            assign sci_all[s] = cfg_arr[s].route_sci;
        end else begin : g_fill
            assign evt_all[s] = 1'b0;
            assign sci_all[s] = 1'b0;
        end
    end

    // groups
    logic [GROUP_SIZE-1:0] own_w  [NUM_GROUPS];
    logic [GROUP_SIZE-1:0] ists_w [NUM_GROUPS];
    logic [GROUP_SIZE-1:0] ien_w  [NUM_GROUPS];
    logic [GROUP_SIZE-1:0] wsts_w [NUM_GROUPS];
    logic [GROUP_SIZE-1:0] wen_w  [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] irq_hits;
    logic [NUM_GROUPS-1:0] wake_hits;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int unsigned LEFT = NUM_PADS - g * GROUP_SIZE;
        localparam int unsigned VPADS = (LEFT < GROUP_SIZE) ? LEFT : GROUP_SIZE;
        logic here;
        assign here = bus_we && grp_sel == GIDX_W'(g);

        gpio_evt_group #(.GROUP_SIZE(GROUP_SIZE), .VALID_PADS(VPADS)) u_grp (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_all[g*GROUP_SIZE +: GROUP_SIZE]),
            .sci      (sci_all[g*GROUP_SIZE +: GROUP_SIZE]),
            .wr_own   (here && sel == SEL_OWN),
            .wr_ists  (here && sel == SEL_ISTS),
            .wr_ien   (here && sel == SEL_IEN),
            .wr_wsts  (here && sel == SEL_WSTS),
            .wr_wen   (here && sel == SEL_WEN),
            .wdata    (bus_wdata[GROUP_SIZE-1:0]),
            .own_q    (own_w[g]),
            .ists_q   (ists_w[g]),
            .ien_q    (ien_w[g]),
            .wsts_q   (wsts_w[g]),
            .wen_q    (wen_w[g]),
            .irq_hit  (irq_hits[g]),
            .wake_hit (wake_hits[g])
        );
    end

    // read path
    logic [31:0] rd_mux;

    always_comb begin
        case (sel)
            SEL_CFG0: rd_mux = cfg_pack(cfg_arr[pad_sel], rx_arr[pad_sel]);
            SEL_OWN:  rd_mux = 32'(own_w[grp_sel]);
            SEL_ISTS: rd_mux = 32'(ists_w[grp_sel]);
            SEL_IEN:  rd_mux = 32'(ien_w[grp_sel]);
            SEL_WSTS: rd_mux = 32'(wsts_w[grp_sel]);
            SEL_WEN:  rd_mux = 32'(wen_w[grp_sel]);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            irq_out   <= 1'b0;
            wake_out  <= 1'b0;
        end else begin
            if (bus_re) bus_rdata <= rd_mux;
            irq_out  <= |irq_hits;
            wake_out <= |wake_hits;
        end
    end

    // R1: the first cycle out of reset shows quiet outputs and no driven pad
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_out && !wake_out && pad_oe == '0));

endmodule

// File: tb/gpio_evt_ctrl_bench.sv
module gpio_evt_ctrl_bench;

    localparam int unsigned NP = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq_out;
    logic          wake_out;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_evt_ctrl #(.NUM_PADS(NP), .GROUP_SIZE(16), .ADDR_W(12)) u_gpio_evt_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out), .wake_out(wake_out)
    );

    function automatic logic [11:0] a_cfg0(input int p); return 12'(12'h400 + 8 * p); endfunction
    function automatic logic [11:0] a_own(input int g);  return 12'(12'h0C0 + 4 * g); endfunction
    function automatic logic [11:0] a_ists(input int g); return 12'(12'h100 + 4 * g); endfunction
    function automatic logic [11:0] a_ien(input int g);  return 12'(12'h120 + 4 * g); endfunction
    function automatic logic [11:0] a_wsts(input int g); return 12'(12'h140 + 4 * g); endfunction
    function automatic logic [11:0] a_wen(input int g);  return 12'(12'h160 + 4 * g); endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(a_cfg0(0), d);  check("R1 cfg pad0", d, 32'h0400_0100);
        rd(a_cfg0(19), d); check("R1 cfg pad19", d, 32'h0400_0100);
        rd(a_ists(0), d);  check("R1 ists g0", d, 0);
        rd(a_ien(1), d);   check("R1 ien g1", d, 0);
        rd(a_own(0), d);   check("R1 own g0", d, 32'h0000_FFFF);
        rd(a_own(1), d);   check("R11 own g1 valid bits", d, 32'h0000_000F);
        check("R1 outputs", {pad_oe, irq_out, wake_out}, 0);
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        pad_in[3] = 1'b1;
        wr(a_cfg0(3), 32'h0400_0003);
        settle();
        rd(a_cfg0(3), d); check("R2 rx high readback", d, 32'h0400_0003);
        check("R2 oe/out driving", {31'(0), pad_oe[3] & pad_out[3]}, 1);
        pad_in[3] = 1'b0;
        settle();
        rd(a_cfg0(3), d); check("R2 rx low readback", d, 32'h0400_0001);
        wr(a_cfg0(3), 32'h0400_0401);
        settle();
        check("R2 non-gpio mode no oe", {31'(0), pad_oe[3]}, 0);
        wr(12'h404 + 12'd24, 32'hFFFF_FFFF);
        rd(12'h404 + 12'd24, d); check("R11 second word zero", d, 0);
        pad_in[4] = 1'b1;
        wr(a_cfg0(4), 32'h0400_0300);
        settle();
        rd(a_cfg0(4), d); check("R2 rx disabled reads 0", d, 32'h0400_0300);
    endtask

    task automatic t_level();
        logic [31:0] d;
        pad_in[5] = 1'b0;
        wr(a_cfg0(5), 32'h0000_0100);
        settle();
        wr(a_ists(0), 32'hFFFF);
        wr(a_ien(0), 32'h20);
        pad_in[5] = 1'b1;
        settle();
        rd(a_ists(0), d); check("R3 level high sets", d, 32'h20);
        check("R8 irq high", {31'(0), irq_out}, 1);
        wr(a_ists(0), 32'h20);
        settle();
        rd(a_ists(0), d); check("R3 level re-sets after clear", d, 32'h20);
        pad_in[5] = 1'b0;
        settle();
        wr(a_ists(0), 32'h20);
        settle();
        rd(a_ists(0), d); check("R3 clear sticks when low", d, 0);
        check("R8 irq drops", {31'(0), irq_out}, 0);
        wr(a_cfg0(5), 32'h0080_0100);
        settle();
        rd(a_ists(0), d); check("R3 active-low level sets", d, 32'h20);
        pad_in[5] = 1'b1;
        settle();
        wr(a_ists(0), 32'hFFFF);
        settle();
        rd(a_ists(0), d); check("R3 active-low high quiet", d, 0);
        wr(a_cfg0(5), 32'h0400_0100);
        wr(a_ien(0), 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        pad_in[6] = 1'b0;
        wr(a_cfg0(6), 32'h0200_0100);
        settle();
        wr(a_ists(0), 32'hFFFF);
        pad_in[6] = 1'b1;
        settle();
        rd(a_ists(0), d); check("R4 rising sets", d, 32'h40);
        wr(a_ists(0), 32'h40);
        settle();
        rd(a_ists(0), d); check("R4 held high no repeat", d, 0);
        pad_in[6] = 1'b0;
        settle();
        rd(a_ists(0), d); check("R4 falling ignored", d, 0);
        wr(a_cfg0(6), 32'h0280_0100);
        settle();
        wr(a_ists(0), 32'hFFFF);
        pad_in[6] = 1'b1;
        settle();
        rd(a_ists(0), d); check("R4 inverted rising ignored", d, 0);
        pad_in[6] = 1'b0;
        settle();
        rd(a_ists(0), d); check("R4 inverted falling sets", d, 32'h40);
        wr(a_cfg0(6), 32'h0400_0100);
        wr(a_ists(0), 32'hFFFF);
    endtask

    task automatic t_both();
        logic [31:0] d;
        pad_in[7] = 1'b0;
        wr(a_cfg0(7), 32'h0600_0100);
        settle();
        wr(a_ists(0), 32'hFFFF);
        pad_in[7] = 1'b1;
        settle();
        rd(a_ists(0), d); check("R5 rise sets", d, 32'h80);
        wr(a_ists(0), 32'h80);
        pad_in[7] = 1'b0;
        settle();
        rd(a_ists(0), d); check("R5 fall sets", d, 32'h80);
        wr(a_cfg0(7), 32'h0400_0100);
        wr(a_ists(0), 32'hFFFF);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        settle();
        wr(a_ists(0), 32'hFFFF);
        pad_in[8] = 1'b1;
        settle();
        pad_in[8] = 1'b0;
        settle();
        pad_in[9] = 1'b0;
        wr(a_cfg0(9), 32'h0080_0300);
        settle();
        rd(a_ists(0), d); check("R6 off code and rx disable quiet", d, 0);
        rd(a_cfg0(9), d); check("R6 rx disabled cfg", d, 32'h0080_0300);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pad_in[10] = 1'b0; pad_in[11] = 1'b0;
        wr(a_cfg0(10), 32'h0200_0100);
        wr(a_cfg0(11), 32'h0200_0100);
        settle();
        wr(a_ists(0), 32'hFFFF);
        pad_in[10] = 1'b1; pad_in[11] = 1'b1;
        settle();
        rd(a_ists(0), d); check("R7 two pads set", d, 32'h0C00);
        wr(a_ists(0), 32'h0400);
        rd(a_ists(0), d); check("R7 single bit clear", d, 32'h0800);
        wr(a_ists(0), 32'hFFFF);
        rd(a_ists(0), d); check("R7 group clear", d, 0);
    endtask

    task automatic t_last_group();
        logic [31:0] d;
        wr(a_ien(1), 32'hFFFF);
        rd(a_ien(1), d); check("R8 unused enable bits zero", d, 32'h000F);
        pad_in[18] = 1'b0;
        wr(a_cfg0(18), 32'h0200_0100);
        settle();
        wr(a_ists(1), 32'hFFFF);
        settle();
        pad_in[18] = 1'b1;
        settle();
        rd(a_ists(1), d); check("R7 pad18 maps to bit 2", d, 32'h0004);
        check("R8 irq from last group", {31'(0), irq_out}, 1);
        wr(a_ists(1), 32'hFFFF);
        settle();
        check("R8 irq cleared", {31'(0), irq_out}, 0);
    endtask

    task automatic t_owner();
        logic [31:0] d;
        wr(a_wsts(1), 32'hFFFF);
        wr(a_own(1), 0);
        pad_in[18] = 1'b0;
        settle();
        pad_in[18] = 1'b1;
        settle();
        rd(a_ists(1), d); check("R9 unowned no status", d, 0);
        rd(a_wsts(1), d); check("R9 unowned no wake status", d, 0);
        rd(a_cfg0(18), d); check("R9 gpio readback still works", d, 32'h0200_0102);
        check("R9 irq stays low", {31'(0), irq_out}, 0);
        wr(a_own(1), 32'hF);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        pad_in[19] = 1'b0;
        wr(a_cfg0(19), 32'h0200_0100);
        settle();
        wr(a_wsts(0), 32'hFFFF);
        wr(a_wsts(1), 32'hFFFF);
        wr(a_wen(1), 32'h8);
        settle();
        check("R10 wake idle", {31'(0), wake_out}, 0);
        pad_in[19] = 1'b1;
        settle();
        rd(a_wsts(1), d); check("R10 wake status bit 3", d, 32'h8);
        check("R10 wake asserted", {31'(0), wake_out}, 1);
        wr(a_cfg0(19), 32'h0208_0100);
        settle();
        check("R10 sci route blocks wake", {31'(0), wake_out}, 0);
        wr(a_cfg0(19), 32'h0200_0100);
        settle();
        check("R10 wake returns", {31'(0), wake_out}, 1);
        wr(a_wsts(1), 32'h8);
        settle();
        check("R10 wake cleared", {31'(0), wake_out}, 0);
        rd(a_wsts(1), d); check("R10 wake status w1c", d, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cfg();
        t_level();
        t_edge();
        t_both();
        t_disabled();
        t_w1c();
        t_last_group();
        t_owner();
        t_wake();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule